// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central bookkeeping of a processor core that issues decoded instructions in program order to a small group of functional units with different latencies. Each unit may then finish out of order. It has three units by default: index 0 is an adder, 1 a multiplier, 2 a divider. There are 16 architectural registers. For every instruction the controller grants four steps in turn: acceptance at issue, reading of operands, execution, and writing of the result. It holds each hazard at one fixed step. Output (WAW) and structural conflicts block issue. True data dependences (RAW) block the operand read, and results are never forwarded. Anti dependences (WAR) block the result write.

The controller keeps three views of machine state. Each unit has an activity step. Each unit also has a status record: busy, operation code, destination, both source registers, the producing unit for each source still outstanding, and a ready flag for each source. Each register has a result-status entry that names the unit that will write it, or shows that no writer is pending. The datapath reads the register file when `rd_grant` is asserted, pulses `fu_done` when execution ends, and writes the register file when `wr_grant` is asserted. The stored operation and register numbers of each unit appear on the `fu_*` outputs.

Top module: `scoreboard_ctl`

## Requirements
- R1: After reset no unit is active and no register has a pending writer. `rd_grant` and `wr_grant` are zero, and a valid issue to any existing unit is accepted at once.
- R2: Unit codes on `iss_unit` are 0 adder, 1 multiplier, 2 divider. Code 3 is always refused. An issue to a unit that still holds an instruction is refused. A unit becomes free in the cycle after its write grant.
- R3: An issue is refused while any unit is pending to write the same destination register, including a unit that writes that register in the same cycle. An accepted issue marks its destination as pending for that unit.
- R4: A unit gets `rd_grant` only when neither source has a pending writer that was recorded at issue. A source whose writer is granted its write in the same cycle as the issue counts as ready. The read grant can come in the cycle right after issue.
- R5: `rd_grant` lasts one cycle per instruction. The unit then executes until its `fu_done` bit is high. A `fu_done` bit is ignored for a unit that is not executing.
- R6: A finished unit gets `wr_grant` only when no other unit holds a source register equal to its destination that it has not yet read. A unit that reads that register in the same cycle still blocks the write.
- R7: A write grant clears the pending status of its destination. Every unit waiting on the writer gets its read grant in the next cycle, if its other source is ready.
- R8: For each unit k, `fu_op`, `fu_src_j`, `fu_src_k` and `fu_dst` at slice k hold the operation code, first source, second source and destination of the instruction last accepted for that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A decoded instruction is offered for issue |
| iss_unit | input | 2 | Target unit: 0 adder, 1 multiplier, 2 divider |
| iss_op | input | 2 | Operation code within the unit |
| iss_dst | input | 4 | Destination register |
| iss_src_j | input | 4 | First source register |
| iss_src_k | input | 4 | Second source register |
| fu_done | input | 3 | Per-unit end-of-execution pulse |
| iss_accept | output | 1 | Offered instruction is taken this cycle |
| rd_grant | output | 3 | Per-unit permission to read operands this cycle |
| wr_grant | output | 3 | Per-unit permission to write its result this cycle |
| fu_op | output | 6 | Per-unit stored operation code, 2 bits per unit |
| fu_src_j | output | 12 | Per-unit first source register, 4 bits per unit |
| fu_src_k | output | 12 | Per-unit second source register, 4 bits per unit |
| fu_dst | output | 12 | Per-unit destination register, 4 bits per unit |

## Verification
A stale register-status entry shows up at `iss_accept` on the next issue that names that register: either a WAW refusal that should not happen, or an accept that should not happen. A ready flag left set or left clear moves a `rd_grant` or a `wr_grant` by one cycle or more. That shift is visible as soon as a dependent instruction reaches that step. The stimulus therefore builds chains of dependent instructions across the units. It checks all three grant outputs in every cycle, so any misplaced wake-up or missing WAR block is seen in the cycle it occurs. It also checks a same-cycle write with an issue, and a done pulse that arrives while a unit is still waiting.

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl #(
  parameter int NFU  = 3,
  parameter int NREG = 16,
  parameter int OPW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [UIW-1:0]        iss_unit,
  input  logic [OPW-1:0]        iss_op,
  input  logic [RW-1:0]         iss_dst,
  input  logic [RW-1:0]         iss_src_j,
  input  logic [RW-1:0]         iss_src_k,
  input  logic [NFU-1:0]        fu_done,
  output logic                  iss_accept,
  output logic [NFU-1:0]        rd_grant,
  output logic [NFU-1:0]        wr_grant,
  output logic [NFU*OPW-1:0]    fu_op,
  output logic [NFU*RW-1:0]     fu_src_j,
  output logic [NFU*RW-1:0]     fu_src_k,
  output logic [NFU*RW-1:0]     fu_dst
);
  localparam int RW  = $clog2(NREG);
  localparam int UIW = (NFU > 1) ? $clog2(NFU) : 1;

  typedef enum logic [1:0] {S_IDLE, S_OPS, S_EXE, S_DONE} step_t;

  step_t            st   [NFU];
  logic [OPW-1:0]   op_q [NFU];
  logic [RW-1:0]    fi   [NFU];
  logic [RW-1:0]    fj   [NFU];
  logic [RW-1:0]    fk   [NFU];
  logic [UIW-1:0]   qj   [NFU];
  logic [UIW-1:0]   qk   [NFU];
  logic             rj   [NFU];
  logic             rk   [NFU];
  logic [NREG-1:0]  rs_v;
  logic [UIW-1:0]   rs_u [NREG];

  logic [NFU-1:0] busy, war_block;
  logic           unit_ok, pend_j, pend_k;

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      busy[u]      = (st[u] != S_IDLE);
      rd_grant[u]  = (st[u] == S_OPS) && rj[u] && rk[u];
      war_block[u] = 1'b0;
      for (int f = 0; f < NFU; f++)
        if (f != u)
          war_block[u] = war_block[u] |
                         ((fj[f] == fi[u]) && rj[f]) |
                         ((fk[f] == fi[u]) && rk[f]);
      wr_grant[u]  = (st[u] == S_DONE) && !war_block[u];
    end
  end

  assign unit_ok    = ({1'b0, iss_unit} < (UIW+1)'(NFU));
  assign iss_accept = iss_valid && unit_ok && !busy[iss_unit] && !rs_v[iss_dst];
  assign pend_j     = rs_v[iss_src_j] && !wr_grant[rs_u[iss_src_j]];
  assign pend_k     = rs_v[iss_src_k] && !wr_grant[rs_u[iss_src_k]];

  for (genvar g = 0; g < NFU; g++) begin : g_out
    assign fu_op[g*OPW +: OPW]   = op_q[g];
    assign fu_src_j[g*RW +: RW]  = fj[g];
    assign fu_src_k[g*RW +: RW]  = fk[g];
    assign fu_dst[g*RW +: RW]    = fi[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_v <= '0;
      for (int r = 0; r < NREG; r++) rs_u[r] <= '0;
      for (int u = 0; u < NFU; u++) begin
        st[u] <= S_IDLE;
        op_q[u] <= '0;
        fi[u] <= '0; fj[u] <= '0; fk[u] <= '0;
        qj[u] <= '0; qk[u] <= '0;
        rj[u] <= 1'b0; rk[u] <= 1'b0;
      end
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (wr_grant[u]) begin
          st[u] <= S_IDLE;
          rs_v[fi[u]] <= 1'b0;
        end else if (rd_grant[u]) begin
          st[u] <= S_EXE;
          rj[u] <= 1'b0;
          rk[u] <= 1'b0;
        end else if (st[u] == S_EXE && fu_done[u]) begin
          st[u] <= S_DONE;
        end
        if (st[u] == S_OPS)
          for (int w = 0; w < NFU; w++)
            if (wr_grant[w]) begin
              if (!rj[u] && qj[u] == UIW'(w)) rj[u] <= 1'b1;
              if (!rk[u] && qk[u] == UIW'(w)) rk[u] <= 1'b1;
            end
      end
      if (iss_accept) begin
        st[iss_unit]   <= S_OPS;
        op_q[iss_unit] <= iss_op;
        fi[iss_unit]   <= iss_dst;
        fj[iss_unit]   <= iss_src_j;
        fk[iss_unit]   <= iss_src_k;
        qj[iss_unit]   <= rs_u[iss_src_j];
        qk[iss_unit]   <= rs_u[iss_src_k];
        rj[iss_unit]   <= !pend_j;
        rk[iss_unit]   <= !pend_k;
        rs_v[iss_dst]  <= 1'b1;
        rs_u[iss_dst]  <= iss_unit;
      end
    end
  end

  AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |=> rs_v[$past(iss_dst)]); // R3
  AST_ISSUE_ARMS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |=> (st[$past(iss_unit)] == S_OPS)); // R2

  for (genvar g = 0; g < NFU; g++) begin : g_chk
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[g] |=> !rd_grant[g]); // R5
    AST_FREE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant[g] |=> !busy[g]); // R2
    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant[g] |=> !rs_v[$past(fi[g])]); // R7
  end
endmodule

// File: tb/scoreboard_ctl_tb.sv
module scoreboard_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_unit = '0;
  logic [1:0] iss_op = '0;
  logic [3:0] iss_dst = '0, iss_src_j = '0, iss_src_k = '0;
  logic [2:0] fu_done = '0;
  logic iss_accept;
  logic [2:0] rd_grant, wr_grant;
  logic [5:0] fu_op;
  logic [11:0] fu_src_j, fu_src_k, fu_dst;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  scoreboard_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_src_j(iss_src_j), .iss_src_k(iss_src_k),
    .fu_done(fu_done), .iss_accept(iss_accept), .rd_grant(rd_grant), .wr_grant(wr_grant),
    .fu_op(fu_op), .fu_src_j(fu_src_j), .fu_src_k(fu_src_k), .fu_dst(fu_dst)
  );

  // {valid, unit, dst, src_j, src_k, done, exp_accept, exp_rd, exp_wr, req}
  function automatic logic [28:0] v(input logic iv, input logic [1:0] iu,
      input logic [3:0] d, input logic [3:0] a, input logic [3:0] b,
      input logic [2:0] dn, input logic ea, input logic [2:0] er,
      input logic [2:0] ew, input logic [3:0] rq);
    return {iv, iu, d, a, b, dn, ea, er, ew, rq};
  endfunction

  localparam int NV = 29;
  localparam logic [28:0] VEC [NV] = '{
    v(1,1,3,1,2,0, 1,3'b000,3'b000, 1),  // R1 mul r3<-r1,r2 on idle block
    v(1,0,5,3,4,0, 1,3'b010,3'b000, 4),  // R4 add waits on r3, mul reads
    v(1,0,7,2,6,0, 0,3'b000,3'b000, 2),  // R2 adder busy
    v(1,2,3,8,9,3'b010, 0,3'b000,3'b000, 3), // R3 WAW on r3
    v(0,0,0,0,0,0, 0,3'b000,3'b010, 7),  // R7 mul writes r3
    v(1,2,3,8,9,0, 1,3'b001,3'b000, 7),  // R7 add woken, r3 free again
    v(1,0,1,1,1,3'b001, 0,3'b100,3'b000, 2), // R2 adder still executing
    v(0,0,0,0,0,0, 0,3'b000,3'b001, 6),
    v(1,3,2,0,0,3'b100, 0,3'b000,3'b000, 2), // R2 unit code 3 refused
    v(0,0,0,0,0,0, 0,3'b000,3'b100, 7),
    v(1,2,1,2,3,0, 1,3'b000,3'b000, 1),  // div r1<-r2,r3
    v(1,1,4,1,5,0, 1,3'b100,3'b000, 4),  // mul r4<-r1,r5 waits on div
    v(1,0,5,6,7,0, 1,3'b000,3'b000, 3),  // add r5 (mul still to read r5)
    v(0,0,0,0,0,0, 0,3'b001,3'b000, 4),
    v(0,0,0,0,0,3'b001, 0,3'b000,3'b000, 5),
    v(0,0,0,0,0,3'b010, 0,3'b000,3'b000, 6), // R6 WAR stall; R5 stray done
    v(0,0,0,0,0,3'b100, 0,3'b000,3'b000, 6),
    v(0,0,0,0,0,0, 0,3'b000,3'b100, 6),
    v(0,0,0,0,0,0, 0,3'b010,3'b000, 6),  // R6 reader in same cycle blocks
    v(0,0,0,0,0,0, 0,3'b000,3'b001, 5),  // R5 mul not finished by stray pulse
    v(0,0,0,0,0,3'b010, 0,3'b000,3'b000, 5),
    v(0,0,0,0,0,0, 0,3'b000,3'b010, 5),
    v(1,1,2,0,0,0, 1,3'b000,3'b000, 1),
    v(0,0,0,0,0,0, 0,3'b010,3'b000, 4),
    v(0,0,0,0,0,3'b010, 0,3'b000,3'b000, 5),
    v(1,0,6,2,0,0, 1,3'b000,3'b010, 4),  // R4 source written in issue cycle
    v(0,0,0,0,0,0, 0,3'b001,3'b000, 4),
    v(0,0,0,0,0,3'b001, 0,3'b000,3'b000, 5),
    v(0,0,0,0,0,0, 0,3'b000,3'b001, 7)
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 accept", 32'(iss_accept), 0);
    chk("R1 rd", 32'(rd_grant), 0);
    chk("R1 wr", 32'(wr_grant), 0);
    for (int i = 0; i < NV; i++) begin
      logic [28:0] e;
      string rq;
      e = VEC[i];
      @(negedge clk);
      iss_valid = e[28]; iss_unit = e[27:26]; iss_dst = e[25:22];
      iss_src_j = e[21:18]; iss_src_k = e[17:14]; fu_done = e[13:11];
      iss_op = 2'd0;
      #5;
      rq = $sformatf("R%0d step %0d", e[3:0], i);
      chk({rq, " accept"}, 32'(iss_accept), 32'(e[10]));
      chk({rq, " rd"}, 32'(rd_grant), 32'(e[9:7]));
      chk({rq, " wr"}, 32'(wr_grant), 32'(e[6:4]));
    end
    // R8: divider fields visible during its read grant
    @(negedge clk);
    iss_valid = 1; iss_unit = 2; iss_op = 2'd3; iss_dst = 9; iss_src_j = 10; iss_src_k = 11;
    fu_done = 0;
    #5 chk("R8 accept", 32'(iss_accept), 1);
    @(negedge clk);
    iss_valid = 0;
    #5;
    chk("R8 rd", 32'(rd_grant), 32'b100);
    chk("R8 op", 32'(fu_op[5:4]), 3);
    chk("R8 src_j", 32'(fu_src_j[11:8]), 10);
    chk("R8 src_k", 32'(fu_src_k[11:8]), 11);
    chk("R8 dst", 32'(fu_dst[11:8]), 9);
    // R3: r9 still pending, divider busy
    @(negedge clk);
    iss_valid = 1; iss_unit = 0; iss_dst = 9; iss_src_j = 0; iss_src_k = 0;
    #5 chk("R3 pending r9", 32'(iss_accept), 0);
    // R1: reset in flight clears everything
    @(negedge clk);
    iss_valid = 0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 rd after reset", 32'(rd_grant), 0);
    chk("R1 wr after reset", 32'(wr_grant), 0);
    @(negedge clk);
    iss_valid = 1; iss_unit = 2; iss_dst = 9; iss_src_j = 1; iss_src_k = 1;
    #5 chk("R1 r9 free after reset", 32'(iss_accept), 1);
    @(negedge clk);
    iss_valid = 0;
    #5 chk("R4 read right after issue", 32'(rd_grant), 32'b100);
    @(negedge clk);
    finish_run();
  end
endmodule